// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Controller

This block is the combinational steering logic for a five-stage in-order integer pipeline. Each cycle it compares register specifiers and control bits from the four pipeline registers and produces two outputs. The first is an operand-source select for each ALU input. The second is the set of enables and flush strobes that stall fetch and decode, or squash them.

Three behaviours are merged here:

- **Forwarding.** A result still in flight in the EX/MEM or MEM/WB register is routed back to the ALU. The younger producer wins when both stages hold the same destination.
- **Load-use stall.** A load followed at once by a consumer of its destination holds fetch and decode for exactly one cycle and sends a bubble into execute.
- **Branch squash.** A branch taken in execute kills the two younger instructions, while fetch keeps running so the target enters the pipe on the next edge.

The pipeline registers, the operand muxes and the ALU sit outside this block. No data is transferred across its boundary: every port is a plain control or specifier pin, so there is no valid/ready handshake and no back-pressure rule to state.

Top module: `hzfw_ctrl`

## Requirements
- R1: Each operand select is one of three codes: 2'b00 selects the register value read in decode, 2'b10 selects the EX/MEM ALU result, 2'b01 selects the MEM/WB writeback data. The code 2'b11 never appears.
- R2: Operand A select is 2'b10 when `exm_reg_wr` is 1, `exm_rd` is nonzero and `exm_rd` equals `ex_rs1`.
- R3: Operand A select is 2'b01 when `wb_reg_wr` is 1, `wb_rd` is nonzero, `wb_rd` equals `ex_rs1`, and the R2 condition is false. When both stages write the matching register, the EX/MEM source wins.
- R4: A source specifier of 0 always yields select 2'b00, whatever the later stages write.
- R5: A load-use hazard exists when `ex_mem_rd` is 1, `ex_rd` is nonzero, and `ex_rd` equals `id_rs1` or `id_rs2`.
- R6: When a load-use hazard exists and no branch is taken, the outputs in that cycle are `pc_we`=0, `ifid_we`=0, `idex_flush`=1 and `ifid_flush`=0.
- R7: When `branch_taken` is 1, the outputs are `ifid_flush`=1, `idex_flush`=1, `pc_we`=1 and `ifid_we`=1.
- R8: If a taken branch and a load-use hazard occur together, the R7 outputs apply and the stall is dropped.
- R9: With no hazard and no matching producer, both selects are 2'b00, both write enables are 1 and both flushes are 0.
- R10: Operand B select follows the rules of R2 to R4 with `ex_rs2` in place of `ex_rs1`, independently of operand A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_rs1 | input | 5 | First source specifier of the instruction in decode |
| id_rs2 | input | 5 | Second source specifier of the instruction in decode |
| ex_rs1 | input | 5 | First source specifier of the instruction in execute |
| ex_rs2 | input | 5 | Second source specifier of the instruction in execute |
| ex_rd | input | 5 | Destination of the instruction in execute |
| ex_mem_rd | input | 1 | Instruction in execute is a memory read |
| exm_rd | input | 5 | Destination held in EX/MEM |
| exm_reg_wr | input | 1 | EX/MEM instruction writes a register |
| wb_rd | input | 5 | Destination held in MEM/WB |
| wb_reg_wr | input | 1 | MEM/WB instruction writes a register |
| branch_taken | input | 1 | Branch resolved taken in execute |
| fwd_a | output | 2 | Source select for the first ALU operand |
| fwd_b | output | 2 | Source select for the second ALU operand |
| pc_we | output | 1 | Program counter write enable |
| ifid_we | output | 1 | IF/ID register write enable |
| ifid_flush | output | 1 | Clear IF/ID to a bubble |
| idex_flush | output | 1 | Clear ID/EX to a bubble |

## Verification
The embedded checks assume that every input is a settled, known level whenever they evaluate. They also treat the register specifiers as opaque 5-bit tags with no relation between the stages, so any combination of matches is legal to present. The stimulus respects this: each input set is applied as a whole, and outputs are read only after a settling delay, never during an edge. The exhaustive sweeps draw specifiers from the values 0 to 3, which covers zero, equal and unequal cases for every comparison pair without assuming any program ordering.

// File: rtl/hzfw_pkg.sv
package hzfw_pkg;

  // Operand source codes; the operand muxes decode these values.
  typedef enum logic [1:0] {
    SRC_RF  = 2'b00,
    SRC_WB  = 2'b01,
    SRC_EXM = 2'b10
  } src_sel_e;

  // Enable / flush bundle for the front of the pipe.
  typedef struct packed {
    logic pc_we;
    logic ifid_we;
    logic ifid_flush;
    logic idex_flush;
  } front_ctl_t;

  localparam front_ctl_t FRONT_RUN = '{pc_we: 1'b1, ifid_we: 1'b1,
                                       ifid_flush: 1'b0, idex_flush: 1'b0};

endpackage

// File: rtl/hzfw_src_pick.sv
module hzfw_src_pick
  import hzfw_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic [AW-1:0] src,
  input  logic [AW-1:0] exm_rd,
  input  logic          exm_wr,
  input  logic [AW-1:0] wb_rd,
  input  logic          wb_wr,
  output src_sel_e      sel
);

  localparam logic [AW-1:0] ZERO_REG = '0;

  logic src_live;
  logic exm_hit;
  logic wb_hit;

  assign src_live = (src != ZERO_REG);
  assign exm_hit  = src_live && exm_wr && (exm_rd == src);
  assign wb_hit   = src_live && wb_wr  && (wb_rd  == src);

  // Younger producer first.
  always_comb begin
    if (exm_hit)     sel = SRC_EXM;
    else if (wb_hit) sel = SRC_WB;
    else             sel = SRC_RF;
  end

  always_comb begin
    // R1
    sel_legal_chk: assert (sel != 2'b11)
      else $error("illegal operand select");
    // R3
    wb_yield_chk: assert (!(sel == SRC_WB && exm_wr && exm_rd == src))
      else $error("MEM/WB chosen over matching EX/MEM");
    // R4
    zero_src_chk: assert (src != ZERO_REG || sel == SRC_RF)
      else $error("register 0 forwarded");
  end

endmodule

// File: rtl/hzfw_load_use.sv
module hzfw_load_use #(
  parameter int AW = 5
) (
  input  logic [AW-1:0] id_rs1,
  input  logic [AW-1:0] id_rs2,
  input  logic [AW-1:0] ex_rd,
  input  logic          ex_mem_rd,
  output logic          hazard
);

  localparam logic [AW-1:0] ZERO_REG = '0;

  logic hit1, hit2;

  assign hit1   = (ex_rd == id_rs1);
  assign hit2   = (ex_rd == id_rs2);
  assign hazard = ex_mem_rd && (ex_rd != ZERO_REG) && (hit1 || hit2);

  always_comb begin
    // R5
    load_only_chk: assert (!hazard || ex_mem_rd)
      else $error("stall raised without a load");
  end

endmodule

// File: rtl/hzfw_front_ctl.sv
module hzfw_front_ctl
  import hzfw_pkg::*;
(
  input  logic       load_use,
  input  logic       branch_taken,
  output front_ctl_t ctl
);

  always_comb begin
    ctl = FRONT_RUN;
    if (branch_taken) begin
      // Redirect wins: fetch keeps running, both younger slots die.
      ctl.ifid_flush = 1'b1;
      ctl.idex_flush = 1'b1;
    end else if (load_use) begin
      ctl.pc_we      = 1'b0;
      ctl.ifid_we    = 1'b0;
      ctl.idex_flush = 1'b1;
    end
  end

  always_comb begin
    // R6
    stall_shape_chk: assert (ctl.pc_we || (!ctl.ifid_we && ctl.idex_flush && !ctl.ifid_flush))
      else $error("malformed stall");
    // R7
    squash_shape_chk: assert (!ctl.ifid_flush || (ctl.pc_we && ctl.ifid_we && ctl.idex_flush))
      else $error("malformed squash");
    // R8
    redirect_run_chk: assert (!branch_taken || (ctl.pc_we && ctl.ifid_we))
      else $error("stall froze a redirect");
  end

endmodule

// File: rtl/hzfw_ctrl.sv
module hzfw_ctrl
  import hzfw_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic [AW-1:0] id_rs1,
  input  logic [AW-1:0] id_rs2,
  input  logic [AW-1:0] ex_rs1,
  input  logic [AW-1:0] ex_rs2,
  input  logic [AW-1:0] ex_rd,
  input  logic          ex_mem_rd,
  input  logic [AW-1:0] exm_rd,
  input  logic          exm_reg_wr,
  input  logic [AW-1:0] wb_rd,
  input  logic          wb_reg_wr,
  input  logic          branch_taken,
  output logic [1:0]    fwd_a,
  output logic [1:0]    fwd_b,
  output logic          pc_we,
  output logic          ifid_we,
  output logic          ifid_flush,
  output logic          idex_flush
);

  localparam int NOPS = 2;

  logic [AW-1:0] ex_src [NOPS];
  src_sel_e      sel    [NOPS];
  logic          load_use;
  front_ctl_t    ctl;

  assign ex_src[0] = ex_rs1;
  assign ex_src[1] = ex_rs2;

  for (genvar g = 0; g < NOPS; g++) begin : g_op
    hzfw_src_pick #(.AW(AW)) u_pick (
      .src    (ex_src[g]),
      .exm_rd (exm_rd),
      .exm_wr (exm_reg_wr),
      .wb_rd  (wb_rd),
      .wb_wr  (wb_reg_wr),
      .sel    (sel[g])
    );
  end

  hzfw_load_use #(.AW(AW)) u_lu (
    .id_rs1    (id_rs1),
    .id_rs2    (id_rs2),
    .ex_rd     (ex_rd),
    .ex_mem_rd (ex_mem_rd),
    .hazard    (load_use)
  );

  hzfw_front_ctl u_front (
    .load_use     (load_use),
    .branch_taken (branch_taken),
    .ctl          (ctl)
  );

  assign fwd_a      = sel[0];
  assign fwd_b      = sel[1];
  assign pc_we      = ctl.pc_we;
  assign ifid_we    = ctl.ifid_we;
  assign ifid_flush = ctl.ifid_flush;
  assign idex_flush = ctl.idex_flush;

  always_comb begin
    // R9
    quiet_default_chk: assert (load_use || branch_taken ||
                               (pc_we && ifid_we && !ifid_flush && !idex_flush))
      else $error("front control active without cause");
  end

endmodule

// File: tb/hzfw_ctrl_tb.sv
module hzfw_ctrl_tb;

  localparam int PERIOD = 8;

  logic clk = 1'b0;
  always #(PERIOD/2) clk = ~clk;

  logic [4:0] id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, exm_rd, wb_rd;
  logic       ex_mem_rd, exm_reg_wr, wb_reg_wr, branch_taken;
  logic [1:0] fwd_a, fwd_b;
  logic       pc_we, ifid_we, ifid_flush, idex_flush;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  hzfw_ctrl u_dut (
    .id_rs1(id_rs1), .id_rs2(id_rs2), .ex_rs1(ex_rs1), .ex_rs2(ex_rs2),
    .ex_rd(ex_rd), .ex_mem_rd(ex_mem_rd), .exm_rd(exm_rd),
    .exm_reg_wr(exm_reg_wr), .wb_rd(wb_rd), .wb_reg_wr(wb_reg_wr),
    .branch_taken(branch_taken), .fwd_a(fwd_a), .fwd_b(fwd_b),
    .pc_we(pc_we), .ifid_we(ifid_we), .ifid_flush(ifid_flush),
    .idex_flush(idex_flush)
  );

  // Vector: {id_rs1,id_rs2,ex_rs1,ex_rs2,ex_rd,ld,exm_rd,exm_wr,wb_rd,wb_wr,br,
  //          exp_fa,exp_fb,exp_pc,exp_ifwe,exp_iff,exp_idf}
  localparam int NV = 13;
  localparam logic [46:0] VEC [NV] = '{
    {5'd0,5'd0,5'd0,5'd0,5'd0,1'b0,5'd0,1'b0,5'd0,1'b0,1'b0, 2'b00,2'b00,4'b1100}, // R9 idle
    {5'd0,5'd0,5'd3,5'd4,5'd0,1'b0,5'd3,1'b1,5'd0,1'b0,1'b0, 2'b10,2'b00,4'b1100}, // R2
    {5'd0,5'd0,5'd1,5'd7,5'd0,1'b0,5'd0,1'b0,5'd7,1'b1,1'b0, 2'b00,2'b01,4'b1100}, // R10
    {5'd0,5'd0,5'd5,5'd6,5'd0,1'b0,5'd5,1'b1,5'd5,1'b1,1'b0, 2'b10,2'b00,4'b1100}, // R3 priority
    {5'd0,5'd0,5'd5,5'd6,5'd0,1'b0,5'd5,1'b0,5'd5,1'b1,1'b0, 2'b01,2'b00,4'b1100}, // R3
    {5'd0,5'd0,5'd0,5'd0,5'd0,1'b0,5'd0,1'b1,5'd0,1'b1,1'b0, 2'b00,2'b00,4'b1100}, // R4
    {5'd7,5'd2,5'd0,5'd0,5'd7,1'b1,5'd0,1'b0,5'd0,1'b0,1'b0, 2'b00,2'b00,4'b0001}, // R5 R6
    {5'd3,5'd9,5'd0,5'd0,5'd9,1'b1,5'd0,1'b0,5'd0,1'b0,1'b0, 2'b00,2'b00,4'b0001}, // R5 rs2
    {5'd0,5'd0,5'd0,5'd0,5'd0,1'b1,5'd0,1'b0,5'd0,1'b0,1'b0, 2'b00,2'b00,4'b1100}, // R5 rd 0
    {5'd7,5'd7,5'd0,5'd0,5'd7,1'b0,5'd0,1'b0,5'd0,1'b0,1'b0, 2'b00,2'b00,4'b1100}, // R5 no load
    {5'd0,5'd0,5'd0,5'd0,5'd0,1'b0,5'd0,1'b0,5'd0,1'b0,1'b1, 2'b00,2'b00,4'b1111}, // R7
    {5'd7,5'd0,5'd0,5'd0,5'd7,1'b1,5'd0,1'b0,5'd0,1'b0,1'b1, 2'b00,2'b00,4'b1111}, // R8
    {5'd0,5'd0,5'd2,5'd2,5'd0,1'b0,5'd2,1'b1,5'd0,1'b0,1'b1, 2'b10,2'b10,4'b1111}  // R7 + R2
  };

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0d expected %0d at %0t", req, got, exp, $time);
    end
  endtask

  function automatic logic [1:0] ref_src(input logic [4:0] s, input logic [4:0] er,
                                         input logic ew, input logic [4:0] wr,
                                         input logic ww);
    if (s == 5'd0)               return 2'b00;
    if (ew && er == s)           return 2'b10;
    if (ww && wr == s)           return 2'b01;
    return 2'b00;
  endfunction

  function automatic logic [3:0] ref_front(input logic [4:0] r1, input logic [4:0] r2,
                                           input logic [4:0] rd, input logic ld,
                                           input logic br);
    if (br) return 4'b1111;
    if (ld && rd != 5'd0 && (rd == r1 || rd == r2)) return 4'b0001;
    return 4'b1100;
  endfunction

  task automatic check_all(input logic [1:0] efa, input logic [1:0] efb,
                           input logic [3:0] efr);
    #2;
    chk("R2 R3 R4 fwd_a", fwd_a, efa);
    chk("R10 fwd_b", fwd_b, efb);
    chk("R6 R7 R9 pc_we", pc_we, efr[3]);
    chk("R6 R7 R9 ifid_we", ifid_we, efr[2]);
    chk("R7 R8 ifid_flush", ifid_flush, efr[1]);
    chk("R6 R7 idex_flush", idex_flush, efr[0]);
    chk("R1 code legal", int'(fwd_a == 2'b11 || fwd_b == 2'b11), 0);
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    {id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, ex_mem_rd,
     exm_rd, exm_reg_wr, wb_rd, wb_reg_wr, branch_taken} = '0;
    @(negedge clk);
    // R9: quiet state with all inputs low
    check_all(2'b00, 2'b00, 4'b1100);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, ex_mem_rd,
       exm_rd, exm_reg_wr, wb_rd, wb_reg_wr, branch_taken} = VEC[i][46:8];
      check_all(VEC[i][7:6], VEC[i][5:4], VEC[i][3:0]);
    end

    // Forwarding sweep (R2 R3 R4 R10), front end idle.
    {id_rs1, id_rs2, ex_rd, ex_mem_rd, branch_taken} = '0;
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++)
        for (int c = 0; c < 4; c++)
          for (int d = 0; d < 4; d++)
            for (int w = 0; w < 4; w++) begin
              ex_rs1 = 5'(a); ex_rs2 = 5'(b); exm_rd = 5'(c); wb_rd = 5'(d);
              exm_reg_wr = w[1]; wb_reg_wr = w[0];
              check_all(ref_src(ex_rs1, exm_rd, exm_reg_wr, wb_rd, wb_reg_wr),
                        ref_src(ex_rs2, exm_rd, exm_reg_wr, wb_rd, wb_reg_wr),
                        4'b1100);
            end

    // Stall / squash sweep (R5 R6 R7 R8), no producers.
    {ex_rs1, ex_rs2, exm_rd, exm_reg_wr, wb_rd, wb_reg_wr} = '0;
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++)
        for (int c = 0; c < 4; c++)
          for (int m = 0; m < 4; m++) begin
            id_rs1 = 5'(a); id_rs2 = 5'(b); ex_rd = 5'(c);
            ex_mem_rd = m[0]; branch_taken = m[1];
            check_all(2'b00, 2'b00,
                      ref_front(id_rs1, id_rs2, ex_rd, ex_mem_rd, branch_taken));
          end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule